// File: doc/BRIEF.md
# Scatter-Gather Descriptor Dispatcher

This block is the register-mapped front end of a scatter-gather DMA channel. Software builds an eight-word transfer descriptor in a write window; the control word, written last with its go bit set, commits the whole descriptor into a descriptor queue. The dispatcher offers queued descriptors one at a time to a transfer engine over a valid/ready port and accepts the engine's completion report over a second valid/ready port. Each completion is stored in a response queue that software drains through a two-word read window.

A small control/status bank gives queue fill levels, sequence numbers, write-one-to-clear status flags, a soft reset with a visible resetting phase, and halt controls. The dispatcher can halt itself after an error or an early termination. An interrupt is raised from per-descriptor enables and an error mask, and is gated by a global enable.

Back-pressure rules: `eng_valid` stays high with `eng_desc` stable until `eng_ready` is seen, and only one descriptor is outstanding at a time. `done_ready` is high only while a descriptor is outstanding and the response queue has room. A completion offered while `done_ready` is low is not taken.

Top module: `sgdma_dispatch`

## Requirements
- R1: A descriptor is eight 32-bit words at window indices 0..7: read address low, write address low, length, burst/sequence (sequence in [15:0]), stride, read address high, write address high, control. Word k appears on `eng_desc[32k+31:32k]`.
- R2: Descriptor words 0..6 only stage values. A write to word 7 with bit 31 set pushes the staged words together with that control word into the descriptor queue. Without bit 31 nothing is queued.
- R3: CSR index 2 reads the descriptor queue level in both [31:16] and [15:0], and index 3 reads the response queue level. Status bits: 1 = descriptor queue empty, 2 = descriptor queue full, 3 = response queue empty, 4 = response queue full. After reset the status reads 0x0000000A.
- R4: Every descriptor window write is dropped while the descriptor queue is full, so the level never exceeds DESC_DEPTH.
- R5: Writing CSR index 1 with bit 1 set starts a soft reset. Status bit 6 reads 1 for RST_CYCLES cycles while both queues, the staging words and the halt flags clear. Control bit 1 always reads 0.
- R6: `eng_valid` is high when the descriptor queue is not empty, nothing is outstanding and no halt is active. An `eng_valid`/`eng_ready` handshake pops the queue. `done_ready` is high only while a descriptor is outstanding.
- R7: Each accepted completion enters the response queue. Response index 0 reads bytes transferred. Index 1 reads the error bits in [7:0] and early termination in bit 8, and a read of index 1 pops one entry.
- R8: Status bit 9 (interrupt pending) is set on a completion when control bit 14 of that descriptor is set, when the error bits AND control bits [23:16] are nonzero, or when the completion is early and control bit 15 is set. Writing 1 to status bit 9 clears it. `irq` = bit 9 AND control bit 4.
- R9: With control bit 2 set, a completion with nonzero error sets status bits 7 and 5 and halts issue. With control bit 3 set, an early completion sets status bits 8 and 5. Writing 1 to bits 7 or 8 clears them and issue resumes. Control bits 0 (stop) and 5 (stop fetching) also halt issue and show as status bit 5.
- R10: CSR index 4 reads, in [15:0], the sequence field of the descriptor last handed to the engine, and in [31:16], that of the descriptor last completed.
- R11: Status bit 0 (busy) is high while the descriptor queue is not empty or a descriptor is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | CSR write strobe |
| csr_addr | input | 3 | CSR word index (byte offset / 4) |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for `csr_addr` |
| dsc_wr | input | 1 | Descriptor window write strobe |
| dsc_addr | input | 3 | Descriptor word index |
| dsc_wdata | input | 32 | Descriptor word data |
| rsp_rd | input | 1 | Response window read strobe |
| rsp_addr | input | 1 | Response word index |
| rsp_rdata | output | 32 | Response read data |
| eng_valid | output | 1 | Descriptor offered to engine |
| eng_ready | input | 1 | Engine accepts descriptor |
| eng_desc | output | 256 | Offered descriptor, word k at bits 32k+31:32k |
| done_valid | input | 1 | Engine reports a completion |
| done_ready | output | 1 | Dispatcher can take a completion |
| done_bytes | input | 32 | Bytes transferred |
| done_err | input | 8 | Error bits |
| done_early | input | 1 | Early termination flag |
| irq | output | 1 | Interrupt request |

## Verification
The commit path is driven with a control write lacking the go bit, with a full committed descriptor, and with writes into a full queue. This separates staging from committing and from dropping. Completions are driven clean, with an error that the descriptor masks out, with an error that it unmasks, and with early termination. Those cases tell the interrupt enables apart from the stop-on-error and stop-on-early flags, and show whether the global enable gates only the pin. The stop bit, the write-one-to-clear resume and the soft reset are each applied with descriptors still queued, so a halt is seen as a held `eng_valid` and a reset as a level drop to zero.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  localparam int WORD_W    = 32;
  localparam int DESC_WRDS = 8;
  localparam int DESC_W    = WORD_W * DESC_WRDS;
  localparam int CTRL_IDX  = DESC_WRDS - 1;

  // descriptor control word bit positions
  localparam int DC_GO      = 31;
  localparam int DC_CMP_IRQ = 14;
  localparam int DC_ERL_IRQ = 15;
  localparam int DC_MASK_LO = 16;

  // CSR word indices
  localparam logic [2:0] CSR_STAT = 3'd0;
  localparam logic [2:0] CSR_CTRL = 3'd1;
  localparam logic [2:0] CSR_DLVL = 3'd2;
  localparam logic [2:0] CSR_RLVL = 3'd3;
  localparam logic [2:0] CSR_SEQ  = 3'd4;

  // control register bits
  localparam int CB_STOP  = 0;
  localparam int CB_RST   = 1;
  localparam int CB_SOE   = 2;
  localparam int CB_SOEA  = 3;
  localparam int CB_GIE   = 4;
  localparam int CB_NOFCH = 5;

  // status bits cleared by writing one
  localparam int SB_ERR  = 7;
  localparam int SB_EARL = 8;
  localparam int SB_IRQ  = 9;

  typedef struct packed {
    logic        early;
    logic [7:0]  err;
    logic [31:0] bytes;
  } rsp_t;
endpackage

// File: rtl/sgd_fifo.sv
module sgd_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         push,
  input  logic [WIDTH-1:0]             din,
  input  logic                         pop,
  output logic [WIDTH-1:0]             dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt_q;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign count   = cnt_q;
  assign dout    = mem_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem_q[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wr_ptr <= adv(wr_ptr);
      if (pop_ok)  rd_ptr <= adv(rd_ptr);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/sgd_xfer_ctl.sv
module sgd_xfer_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        halt,
  input  logic        desc_empty,
  input  logic [31:0] head_ctrl,
  input  logic [15:0] head_seq,
  input  logic        eng_ready,
  input  logic        done_valid,
  input  logic [7:0]  done_err,
  input  logic        done_early,
  input  logic        rsp_full,
  output logic        eng_valid,
  output logic        desc_pop,
  output logic        done_ready,
  output logic        cmpl,
  output logic        in_flight,
  output logic        raise_irq,
  output logic        err_seen,
  output logic        early_seen,
  output logic [15:0] rd_seq,
  output logic [15:0] wr_seq
);
  import sgd_pkg::*;

  logic [31:0] cur_ctrl;
  logic [15:0] cur_seq;
  logic        mask_hit;

  assign eng_valid  = !in_flight && !desc_empty && !halt;
  assign desc_pop   = eng_valid && eng_ready;
  assign done_ready = in_flight && !rsp_full && !clr;
  assign cmpl       = done_valid && done_ready;

  assign mask_hit   = |(done_err & cur_ctrl[DC_MASK_LO +: 8]);
  assign raise_irq  = cmpl && (cur_ctrl[DC_CMP_IRQ] || mask_hit ||
                               (done_early && cur_ctrl[DC_ERL_IRQ]));
  assign err_seen   = cmpl && (|done_err);
  assign early_seen = cmpl && done_early;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      in_flight <= 1'b0;
      cur_ctrl  <= '0;
      cur_seq   <= '0;
      rd_seq    <= '0;
      wr_seq    <= '0;
    end else if (desc_pop) begin
      in_flight <= 1'b1;
      cur_ctrl  <= head_ctrl;
      cur_seq   <= head_seq;
      rd_seq    <= head_seq;
    end else if (cmpl) begin
      in_flight <= 1'b0;
      wr_seq    <= cur_seq;
    end
  end
endmodule

// File: rtl/sgdma_dispatch.sv
module sgdma_dispatch
  import sgd_pkg::*;
#(
  parameter int DESC_DEPTH = 4,
  parameter int RSP_DEPTH  = 4,
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_wr,
  input  logic [2:0]  csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic        dsc_wr,
  input  logic [2:0]  dsc_addr,
  input  logic [31:0] dsc_wdata,
  input  logic        rsp_rd,
  input  logic        rsp_addr,
  output logic [31:0] rsp_rdata,
  output logic        eng_valid,
  input  logic        eng_ready,
  output logic [255:0] eng_desc,
  input  logic        done_valid,
  output logic        done_ready,
  input  logic [31:0] done_bytes,
  input  logic [7:0]  done_err,
  input  logic        done_early,
  output logic        irq
);
  localparam int DCW  = $clog2(DESC_DEPTH + 1);
  localparam int RCW  = $clog2(RSP_DEPTH + 1);
  localparam int RSTW = $clog2(RST_CYCLES + 1);
  localparam int RSPW = $bits(rsp_t);

  // staging and commit
  logic [31:0] stage_q [CTRL_IDX];
  logic [DESC_W-1:0] commit_word;
  logic        dsc_accept, commit;

  // queues
  logic [DCW-1:0] desc_cnt;
  logic           desc_full, desc_empty, desc_pop;
  logic [RCW-1:0] rsp_cnt;
  logic           rsp_full, rsp_empty, rsp_pop, rsp_push;
  rsp_t           rsp_in, rsp_head;
  logic [RSPW-1:0] rsp_head_bits;

  // control and status
  logic [5:0]     ctl_reg;
  logic           resetting;
  logic [RSTW-1:0] rst_cnt;
  logic           rst_trig;
  logic           err_f, early_f, irq_pend;
  logic           halt, stopped, busy;
  logic           cmpl, in_flight, raise_irq, err_seen, early_seen;
  logic [15:0]    rd_seq, wr_seq;
  logic [9:0]     status;

  assign dsc_accept = dsc_wr && !desc_full && !resetting;
  assign commit     = dsc_accept && (dsc_addr == 3'(CTRL_IDX)) && dsc_wdata[DC_GO];

  always_comb begin
    commit_word = '0;
    for (int k = 0; k < CTRL_IDX; k++) commit_word[WORD_W*k +: WORD_W] = stage_q[k];
    commit_word[WORD_W*CTRL_IDX +: WORD_W] = dsc_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || resetting) begin
      for (int k = 0; k < CTRL_IDX; k++) stage_q[k] <= '0;
    end else if (dsc_accept && (dsc_addr != 3'(CTRL_IDX))) begin
      stage_q[dsc_addr] <= dsc_wdata;
    end
  end

  sgd_fifo #(.WIDTH(DESC_W), .DEPTH(DESC_DEPTH)) u_dq (
    .clk(clk), .rst_n(rst_n), .clr(resetting),
    .push(commit), .din(commit_word), .pop(desc_pop),
    .dout(eng_desc), .count(desc_cnt), .full(desc_full), .empty(desc_empty)
  );

  assign halt    = ctl_reg[CB_STOP] || ctl_reg[CB_NOFCH] || err_f || early_f || resetting;
  assign stopped = ctl_reg[CB_STOP] || ctl_reg[CB_NOFCH] || err_f || early_f;

  sgd_xfer_ctl u_xfer (
    .clk(clk), .rst_n(rst_n), .clr(resetting), .halt(halt),
    .desc_empty(desc_empty),
    .head_ctrl(eng_desc[WORD_W*CTRL_IDX +: WORD_W]),
    .head_seq(eng_desc[WORD_W*3 +: 16]),
    .eng_ready(eng_ready), .done_valid(done_valid), .done_err(done_err),
    .done_early(done_early), .rsp_full(rsp_full),
    .eng_valid(eng_valid), .desc_pop(desc_pop), .done_ready(done_ready),
    .cmpl(cmpl), .in_flight(in_flight), .raise_irq(raise_irq),
    .err_seen(err_seen), .early_seen(early_seen),
    .rd_seq(rd_seq), .wr_seq(wr_seq)
  );

  assign rsp_push = cmpl;
  assign rsp_in   = '{early: done_early, err: done_err, bytes: done_bytes};
  assign rsp_pop  = rsp_rd && rsp_addr && !rsp_empty;
  assign rsp_head = rsp_t'(rsp_head_bits);

  sgd_fifo #(.WIDTH(RSPW), .DEPTH(RSP_DEPTH)) u_rq (
    .clk(clk), .rst_n(rst_n), .clr(resetting),
    .push(rsp_push), .din(rsp_in), .pop(rsp_pop),
    .dout(rsp_head_bits), .count(rsp_cnt), .full(rsp_full), .empty(rsp_empty)
  );

  assign rsp_rdata = rsp_addr ? {23'd0, rsp_head.early, rsp_head.err} : rsp_head.bytes;

  // control register; the reset bit is a trigger and is never stored
  assign rst_trig = csr_wr && (csr_addr == CSR_CTRL) && csr_wdata[CB_RST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_reg <= '0;
    end else if (csr_wr && (csr_addr == CSR_CTRL)) begin
      ctl_reg <= {csr_wdata[5:2], 1'b0, csr_wdata[0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resetting <= 1'b0;
      rst_cnt   <= '0;
    end else if (rst_trig) begin
      resetting <= 1'b1;
      rst_cnt   <= RSTW'(RST_CYCLES - 1);
    end else if (resetting) begin
      if (rst_cnt == '0) resetting <= 1'b0;
      else               rst_cnt   <= rst_cnt - 1'b1;
    end
  end

  // sticky status flags: set wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n || resetting) begin
      err_f    <= 1'b0;
      early_f  <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      if (csr_wr && (csr_addr == CSR_STAT)) begin
        if (csr_wdata[SB_ERR])  err_f    <= 1'b0;
        if (csr_wdata[SB_EARL]) early_f  <= 1'b0;
        if (csr_wdata[SB_IRQ])  irq_pend <= 1'b0;
      end
      if (err_seen && ctl_reg[CB_SOE])    err_f    <= 1'b1;
      if (early_seen && ctl_reg[CB_SOEA]) early_f  <= 1'b1;
      if (raise_irq)                      irq_pend <= 1'b1;
    end
  end

  assign irq  = irq_pend && ctl_reg[CB_GIE];
  assign busy = in_flight || !desc_empty;

  assign status = {irq_pend, early_f, err_f, resetting, stopped,
                   rsp_full, rsp_empty, desc_full, desc_empty, busy};

  always_comb begin
    unique case (csr_addr)
      CSR_STAT: csr_rdata = {22'd0, status};
      CSR_CTRL: csr_rdata = {26'd0, ctl_reg};
      CSR_DLVL: csr_rdata = {16'(desc_cnt), 16'(desc_cnt)};
      CSR_RLVL: csr_rdata = {16'd0, 16'(rsp_cnt)};
      CSR_SEQ:  csr_rdata = {wr_seq, rd_seq};
      default:  csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sgdma_dispatch_chk.sv
module sgdma_dispatch_chk #(
  parameter int DESC_DEPTH = 4,
  parameter int RSP_DEPTH  = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        dsc_wr,
  input logic [2:0]  dsc_addr,
  input logic [31:0] dsc_wdata,
  input logic        eng_valid,
  input logic        done_valid,
  input logic        done_ready,
  input logic [7:0]  done_err,
  input logic [$clog2(DESC_DEPTH+1)-1:0] desc_cnt,
  input logic [$clog2(RSP_DEPTH+1)-1:0]  rsp_cnt,
  input logic        resetting,
  input logic [5:0]  ctl_reg,
  input logic        irq_pend
);
  // R2: the queue only grows after a go-bit control write
  a_r2_commit_on_go: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_cnt > $past(desc_cnt)) |-> $past(dsc_wr && (dsc_addr == 3'd7) && dsc_wdata[31]));

  // R4: descriptor queue never exceeds its depth
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    desc_cnt <= ($clog2(DESC_DEPTH+1))'(DESC_DEPTH));

  // R7: response queue never exceeds its depth
  a_r7_rsp_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cnt <= ($clog2(RSP_DEPTH+1))'(RSP_DEPTH));

  // R6: one outstanding descriptor at most
  a_r6_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    done_ready |-> !eng_valid);

  // R5: no engine traffic while resetting
  a_r5_quiet_reset: assert property (@(posedge clk) disable iff (!rst_n)
    resetting |-> (!eng_valid && !done_ready));

  // R9: an error completion with stop-on-error halts issue
  a_r9_halt_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_ready && (|done_err) && ctl_reg[2]) |=> !eng_valid);

  // R8: interrupt pending only rises on an accepted completion
  a_r8_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(done_valid && done_ready));
endmodule

bind sgdma_dispatch sgdma_dispatch_chk #(.DESC_DEPTH(DESC_DEPTH), .RSP_DEPTH(RSP_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .dsc_wr(dsc_wr), .dsc_addr(dsc_addr), .dsc_wdata(dsc_wdata),
  .eng_valid(eng_valid), .done_valid(done_valid), .done_ready(done_ready),
  .done_err(done_err), .desc_cnt(desc_cnt), .rsp_cnt(rsp_cnt),
  .resetting(resetting), .ctl_reg(ctl_reg), .irq_pend(irq_pend)
);

// File: tb/sim_sgdma_dispatch.sv
module sim_sgdma_dispatch;
  localparam int DEPTH = 4;
  localparam int RSTC  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr = 1'b0;
  logic [2:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        dsc_wr = 1'b0;
  logic [2:0]  dsc_addr = '0;
  logic [31:0] dsc_wdata = '0;
  logic        rsp_rd = 1'b0;
  logic        rsp_addr = 1'b0;
  logic [31:0] rsp_rdata;
  logic        eng_valid;
  logic        eng_ready = 1'b0;
  logic [255:0] eng_desc;
  logic        done_valid = 1'b0;
  logic        done_ready;
  logic [31:0] done_bytes = '0;
  logic [7:0]  done_err = '0;
  logic        done_early = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sgdma_dispatch #(.DESC_DEPTH(DEPTH), .RSP_DEPTH(4), .RST_CYCLES(RSTC)) u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr_csr(input logic [2:0] a, input logic [31:0] d);
    csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic rd_csr(input logic [2:0] a, output logic [31:0] d);
    csr_addr = a; #1; d = csr_rdata;
  endtask

  task automatic wr_desc(input logic [31:0] w [8]);
    for (int k = 0; k < 8; k++) begin
      dsc_wr = 1'b1; dsc_addr = 3'(k); dsc_wdata = w[k];
      @(negedge clk);
    end
    dsc_wr = 1'b0;
  endtask

  task automatic issue();
    eng_ready = 1'b1;
    @(negedge clk);
    eng_ready = 1'b0;
  endtask

  task automatic complete(input logic [31:0] b, input logic [7:0] e, input logic early);
    done_valid = 1'b1; done_bytes = b; done_err = e; done_early = early;
    @(negedge clk);
    done_valid = 1'b0; done_err = '0; done_early = 1'b0;
  endtask

  task automatic pop_rsp(output logic [31:0] b, output logic [31:0] s);
    rsp_addr = 1'b0; #1; b = rsp_rdata;
    rsp_addr = 1'b1; #1; s = rsp_rdata;
    rsp_rd = 1'b1;
    @(negedge clk);
    rsp_rd = 1'b0;
  endtask

  function automatic void mk(output logic [31:0] w [8], input logic [15:0] seq, input logic [31:0] ctl);
    w[0] = 32'h1000_0000 + 32'(seq); w[1] = 32'h2000_0000; w[2] = 32'h40;
    w[3] = {16'h0, seq}; w[4] = 32'h0001_0001; w[5] = 32'hA; w[6] = 32'hB; w[7] = ctl;
  endfunction

  task automatic t_reset_state();
    logic [31:0] d;
    rd_csr(3'd0, d);
    check("R3 status after reset", d, 32'h0000_000A);
    check("R11 idle after reset", {31'd0, irq | eng_valid}, 32'd0);
  endtask

  task automatic t_commit_and_complete();
    logic [31:0] w [8];
    logic [31:0] d, b, s;
    wr_csr(3'd1, 32'h10);
    mk(w, 16'h1234, 32'h0000_4000);
    wr_desc(w);
    rd_csr(3'd2, d);
    check("R2 no go bit queues nothing", d, 32'd0);
    w[7] = 32'h8000_4000;
    wr_desc(w);
    rd_csr(3'd2, d);
    check("R2 go bit commits", d, 32'h0001_0001);
    check("R1 word0 on engine port", eng_desc[31:0], 32'h1000_1234);
    check("R1 length word", eng_desc[95:64], 32'h40);
    check("R1 control word", eng_desc[255:224], 32'h8000_4000);
    check("R6 offered", {31'd0, eng_valid}, 32'd1);
    issue();
    check("R6 one outstanding", {30'd0, eng_valid, done_ready}, 32'd1);
    rd_csr(3'd0, d);
    check("R11 busy while outstanding", d & 32'h3, 32'h3);
    rd_csr(3'd4, d);
    check("R10 read sequence", d, 32'h0000_1234);
    complete(32'h40, 8'h0, 1'b0);
    rd_csr(3'd3, d);
    check("R3 response level", d, 32'd1);
    rd_csr(3'd0, d);
    check("R8 completion irq pending", d & 32'h200, 32'h200);
    check("R8 irq pin", {31'd0, irq}, 32'd1);
    rd_csr(3'd4, d);
    check("R10 write sequence", d, 32'h1234_1234);
    pop_rsp(b, s);
    check("R7 bytes", b, 32'h40);
    check("R7 status word", s, 32'h0);
    rd_csr(3'd3, d);
    check("R7 pop", d, 32'd0);
    wr_csr(3'd0, 32'h200);
    rd_csr(3'd0, d);
    check("R8 w1c irq", d & 32'h200, 32'd0);
    check("R8 irq pin cleared", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_full_and_reset();
    logic [31:0] w [8];
    logic [31:0] d;
    for (int i = 0; i < DEPTH + 1; i++) begin
      mk(w, 16'(i), 32'h8000_0000);
      wr_desc(w);
    end
    rd_csr(3'd2, d);
    check("R4 dropped when full", d, 32'h0004_0004);
    rd_csr(3'd0, d);
    check("R3 full flag", d & 32'h6, 32'h4);
    wr_csr(3'd1, 32'h2);
    rd_csr(3'd0, d);
    check("R5 resetting set", d & 32'h40, 32'h40);
    rd_csr(3'd1, d);
    check("R5 reset bit reads 0", d, 32'h0);
    repeat (RSTC) @(negedge clk);
    rd_csr(3'd0, d);
    check("R5 reset done", d, 32'h0000_000A);
  endtask

  task automatic t_stop_on_error();
    logic [31:0] w [8];
    logic [31:0] d, b, s;
    wr_csr(3'd1, 32'h14);
    mk(w, 16'h0011, 32'h8000_0000);
    wr_desc(w);
    mk(w, 16'h0022, 32'h8002_0000);
    wr_desc(w);
    issue();
    complete(32'h8, 8'h01, 1'b0);
    rd_csr(3'd0, d);
    check("R9 stopped on error", d & 32'h2A0, 32'h0A0);
    check("R9 issue halted", {31'd0, eng_valid}, 32'd0);
    pop_rsp(b, s);
    check("R7 error bits", s, 32'h1);
    wr_csr(3'd0, 32'h80);
    check("R9 resume after w1c", {31'd0, eng_valid}, 32'd1);
    issue();
    complete(32'h8, 8'h02, 1'b0);
    rd_csr(3'd0, d);
    check("R8 masked error irq", d & 32'h200, 32'h200);
    pop_rsp(b, s);
    wr_csr(3'd0, 32'h280);
  endtask

  task automatic t_early_gate();
    logic [31:0] w [8];
    logic [31:0] d, b, s;
    wr_csr(3'd1, 32'h08);
    mk(w, 16'h0033, 32'h8000_8000);
    wr_desc(w);
    issue();
    complete(32'h4, 8'h0, 1'b1);
    rd_csr(3'd0, d);
    check("R9 stopped on early", d & 32'h3A0, 32'h320);
    check("R8 irq gated by global enable", {31'd0, irq}, 32'd0);
    pop_rsp(b, s);
    check("R7 early flag", s, 32'h100);
    wr_csr(3'd1, 32'h18);
    check("R8 irq with global enable", {31'd0, irq}, 32'd1);
    wr_csr(3'd0, 32'h300);
  endtask

  task automatic t_ctl_stop();
    logic [31:0] w [8];
    logic [31:0] d, b, s;
    wr_csr(3'd1, 32'h01);
    mk(w, 16'h0044, 32'h8000_0000);
    wr_desc(w);
    rd_csr(3'd0, d);
    check("R9 stop bit halts", {d[5], eng_valid}, 32'h2);
    wr_csr(3'd1, 32'h20);
    check("R9 stop-fetch halts", {31'd0, eng_valid}, 32'd0);
    wr_csr(3'd1, 32'h00);
    check("R9 resume after stop", {31'd0, eng_valid}, 32'd1);
    issue();
    complete(32'h10, 8'h0, 1'b0);
    pop_rsp(b, s);
    check("R7 bytes after stop", b, 32'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_commit_and_complete();
    t_full_and_reset();
    t_stop_on_error();
    t_early_gate();
    t_ctl_stop();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule